// File: doc/BRIEF.md
# Dual-Enable Static RAM Model

A synthesizable, clock-sampled model of a byte-wide static RAM with a deselect-by-either-enable scheme. One active-low and one active-high chip select must both be true before the part responds. The active-low write strobe then chooses between driving a stored word and accepting one. The bidirectional data bus is split into an input, an output and an output-enable flag, so the model can sit behind a tristate pad or feed a multiplexer on an FPGA. The full 32K x 8 organisation is obtained with `ADDR_W = 15`. The default is a smaller array so that the model elaborates quickly.

Every control pin is sampled on the rising clock edge. Real analog delays become parameterised edge counts: the bus turns on `RD_ON_DLY` edges after read mode is first seen, and turns off `RD_OFF_DLY` edges after deselection. A write takes the bus away at once. A write commits only when the three-way overlap of the two selects and the write strobe ends, and the committed word is the last one sampled inside that overlap. No reset clears the array, and its power-up contents are undefined.

Top module: `sram_dual_ce`

## Requirements
- R1: When `ce1_ni` is 1 or `ce2_i` is 0 at a sampling edge, no word is stored at that edge, whatever the levels of `we_ni` and `din_i`.
- R2: The first edge that samples a deselected state starts a count. `oe_o` falls at the `RD_OFF_DLY`-th consecutive deselected edge and then stays 0 while deselection holds. If read mode returns before the count completes, `oe_o` stays 1.
- R3: In read mode (`ce1_ni`=0, `ce2_i`=1, `we_ni`=1), the edge that samples an address loads the word stored there into the output register. This includes a word whose write ended at that same edge.
- R4: Write mode is `ce1_ni`=0, `ce2_i`=1, `we_ni`=0. The array changes only at the first edge after a run of write-mode edges. The word stored is the `din_i` and address sampled at the last edge of that run.
- R5: After any edge that samples `we_ni`=0 while selected, `oe_o` is 0.
- R6: When selection is applied at the same edge as `we_ni`=0, or later, `oe_o` stays 0 for the whole write, whichever enable is the last to arrive.
- R7: `oe_o` rises at the `RD_ON_DLY`-th consecutive edge in read mode, counted from the first read-mode edge after a write or a deselected period.
- R9: After reset, `oe_o` is 0. Whenever `oe_o` is 0, `dout_o` is all zeros.
- R10: When the address changes during a read, `dout_o` keeps the previous word until the first edge that samples the new address.
- R11: Reset clears only the control state. A word written before a reset pulse reads back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset of control state |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Data bus, inbound half |
| ce1_ni | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Chip select, active high |
| we_ni | input | 1 | Write strobe, active low |
| dout_o | output | DATA_W | Data bus, outbound half (zero when not driving) |
| oe_o | output | 1 | Bus drive enable |

## Verification
Writes are applied with the write strobe leading, with the active-low select arriving last and with the active-high select arriving last. A write whose data changes inside the overlap separates "last sampled word" from "first sampled word". Reads are applied back to back at different addresses, directly after a write and across a reset pulse. These separate latency and hold behaviour from correct storage and from wrongful clearing of the array. Deselection through each enable, a re-selection in the middle of the turn-off count, and write attempts with one enable false expose a wrong mode decode and wrong bus-timing counters.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_RD   = 2'd1,
    MODE_WR   = 2'd2
  } mode_e;
endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_pkg::*;
(
  input  logic  ce1_ni,
  input  logic  ce2_i,
  input  logic  we_ni,
  output mode_e mode_o
);
  logic sel;
  assign sel = !ce1_ni && ce2_i;

  always_comb begin
    if (!sel)       mode_o = MODE_IDLE;
    else if (we_ni) mode_o = MODE_RD;
    else            mode_o = MODE_WR;
  end
endmodule

// File: rtl/sram_store.sv
module sram_store
  import sram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  // array has no reset: contents undefined until written
  logic [DATA_W-1:0] mem [DEPTH];

  logic              pend_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;
  logic              is_wr, is_rd, commit;

  assign is_wr  = (mode_i == MODE_WR);
  assign is_rd  = (mode_i == MODE_RD);
  assign commit = pend_q && !is_wr;

  always_ff @(posedge clk_i) begin
    if (commit) mem[wa_q] <= wd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      pend_q <= is_wr;
      if (is_wr) begin
        wa_q <= addr_i;
        wd_q <= din_i;
      end
      // forward a word committed at this same edge
      if (is_rd) rd_q <= (commit && wa_q == addr_i) ? wd_q : mem[addr_i];
    end
  end

  assign rdata_o = rd_q;

  // R4: a commit only follows an edge that saw the write overlap
  a_r4_commit_after_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> $past(mode_i) == MODE_WR);
endmodule

// File: rtl/sram_oe_ctl.sv
module sram_oe_ctl
  import sram_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RD_ON_DLY  = 2,
  parameter int RD_OFF_DLY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              oe_o,
  output logic [DATA_W-1:0] dout_o
);
  localparam int ON_W  = (RD_ON_DLY  > 1) ? $clog2(RD_ON_DLY)  : 1;
  localparam int OFF_W = (RD_OFF_DLY > 1) ? $clog2(RD_OFF_DLY) : 1;
  localparam logic [ON_W-1:0]  ON_LAST  = ON_W'(RD_ON_DLY - 1);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(RD_OFF_DLY - 1);

  logic             oe_q;
  logic [ON_W-1:0]  on_cnt;
  logic [OFF_W-1:0] off_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q    <= 1'b0;
      on_cnt  <= '0;
      off_cnt <= '0;
    end else begin
      unique case (mode_i)
        MODE_RD: begin
          off_cnt <= '0;
          if (!oe_q) begin
            if (on_cnt == ON_LAST) begin
              oe_q   <= 1'b1;
              on_cnt <= '0;
            end else begin
              on_cnt <= on_cnt + 1'b1;
            end
          end
        end
        MODE_WR: begin
          // write owns the bus at once
          oe_q    <= 1'b0;
          on_cnt  <= '0;
          off_cnt <= '0;
        end
        default: begin
          on_cnt <= '0;
          if (oe_q) begin
            if (off_cnt == OFF_LAST) begin
              oe_q    <= 1'b0;
              off_cnt <= '0;
            end else begin
              off_cnt <= off_cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign oe_o   = oe_q;
  assign dout_o = oe_q ? rdata_i : '0;

  // R5: a sampled write leaves the bus undriven
  a_r5_z_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_WR |=> !oe_o);
  // R7: drive only begins out of read mode
  a_r7_rise_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(mode_i) == MODE_RD);
  // R2: once off, deselection keeps it off
  a_r2_idle_stays_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_IDLE && !oe_o) |=> !oe_o);
endmodule

// File: rtl/sram_dual_ce.sv
module sram_dual_ce
  import sram_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int RD_ON_DLY  = 2,
  parameter int RD_OFF_DLY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              we_ni,
  output logic [DATA_W-1:0] dout_o,
  output logic              oe_o
);
  mode_e             mode;
  logic [DATA_W-1:0] rdata;

  sram_mode_dec i_dec (
    .ce1_ni (ce1_ni),
    .ce2_i  (ce2_i),
    .we_ni  (we_ni),
    .mode_o (mode)
  );

  sram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .addr_i  (addr_i),
    .din_i   (din_i),
    .rdata_o (rdata)
  );

  sram_oe_ctl #(.DATA_W(DATA_W), .RD_ON_DLY(RD_ON_DLY), .RD_OFF_DLY(RD_OFF_DLY)) i_oe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .rdata_i (rdata),
    .oe_o    (oe_o),
    .dout_o  (dout_o)
  );
endmodule

// File: tb/test_sram_dual_ce.sv
module test_sram_dual_ce;
  localparam int AW     = 11;
  localparam int DW     = 8;
  localparam int ON_DLY = 2;
  localparam int OFF_DLY = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] din_i = '0;
  logic          ce1_ni = 1'b1, ce2_i = 1'b0, we_ni = 1'b1;
  logic [DW-1:0] dout_o;
  logic          oe_o;

  sram_dual_ce #(.ADDR_W(AW), .DATA_W(DW), .RD_ON_DLY(ON_DLY), .RD_OFF_DLY(OFF_DLY)) i_sram_dual_ce (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .din_i(din_i),
    .ce1_ni(ce1_ni), .ce2_i(ce2_i), .we_ni(we_ni), .dout_o(dout_o), .oe_o(oe_o)
  );

  always #5 clk = ~clk;

  typedef struct packed { logic oe; logic [DW-1:0] d; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_bad = 0;
  bit    started = 0;

  // reference state, built from the requirements
  logic [DW-1:0] bmem [1 << AW];
  logic          m_oe = 0, m_pend = 0;
  logic [AW-1:0] m_wa = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;
  int            m_on = 0, m_off = 0;

  task automatic check(input bit ok, input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got oe/dout=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic c1n, input logic c2, input logic wn,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    int md;
    @(negedge clk);
    rst_ni = 1'b1;
    ce1_ni = c1n; ce2_i = c2; we_ni = wn; addr_i = a; din_i = d;
    md = (c1n || !c2) ? 0 : (wn ? 1 : 2);
    if (m_pend && md != 2) begin bmem[m_wa] = m_wd; m_pend = 0; end
    if (md == 2) begin m_pend = 1; m_wa = a; m_wd = d; end
    if (md == 1) m_rd = bmem[a];
    if (md == 1) begin
      m_off = 0; m_on++;
      if (m_on >= ON_DLY) m_oe = 1;
    end else if (md == 2) begin
      m_on = 0; m_off = 0; m_oe = 0;
    end else begin
      m_on = 0;
      if (m_oe) begin m_off++; if (m_off >= OFF_DLY) begin m_oe = 0; m_off = 0; end end
    end
    exp_q.push_back('{oe: m_oe, d: m_oe ? m_rd : '0});
    tag_q.push_back(tag);
  endtask

  task automatic pulse_reset(input string tag);
    @(negedge clk);
    rst_ni = 1'b0; ce1_ni = 1'b1; ce2_i = 1'b0; we_ni = 1'b1;
    m_oe = 0; m_pend = 0; m_on = 0; m_off = 0; m_rd = '0;
    exp_q.push_back('{oe: 1'b0, d: '0});
    tag_q.push_back(tag);
  endtask

  // monitor: compare each result a little after the edge that makes it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (started && exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(oe_o === e.oe && dout_o === e.d, t, {oe_o, dout_o}, {e.oe, e.d});
      end
    end
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9: reset state
    check(oe_o === 1'b0 && dout_o === '0, "R9", {oe_o, dout_o}, '0);
    rst_ni = 1'b1;
    started = 1;
    cyc(1, 0, 1, 0, 0, "R9");

    // R4: write led by we; data changes inside the overlap, last one wins
    cyc(1, 1, 0, 11'd5, 8'h11, "R6");
    cyc(0, 1, 0, 11'd5, 8'h11, "R4");
    cyc(0, 1, 0, 11'd5, 8'h3C, "R4");
    cyc(1, 1, 1, 11'd5, 8'h00, "R4");

    // R6: ce2 arrives last
    cyc(0, 0, 0, 11'h7FF, 8'hA5, "R6");
    cyc(0, 1, 0, 11'h7FF, 8'hA5, "R6");
    cyc(0, 1, 0, 11'h7FF, 8'hA5, "R6");
    cyc(0, 0, 1, 11'h7FF, 8'h00, "R6");

    // R7/R3: read addr 5
    cyc(0, 1, 1, 11'd5, 0, "R7");
    cyc(0, 1, 1, 11'd5, 0, "R7");
    cyc(0, 1, 1, 11'd5, 0, "R3");
    // R10: address change holds old word until sampled
    cyc(0, 1, 1, 11'h7FF, 0, "R3");
    #1 check(dout_o === 8'h3C && oe_o === 1'b1, "R10", {oe_o, dout_o}, {1'b1, 8'h3C});
    cyc(0, 1, 1, 11'h7FF, 0, "R3");

    // R5: write during read drops the bus; read-after-write
    cyc(0, 1, 0, 11'd9, 8'h5A, "R5");
    cyc(0, 1, 0, 11'd9, 8'h5A, "R5");
    cyc(0, 1, 1, 11'd9, 0, "R3");
    cyc(0, 1, 1, 11'd9, 0, "R3");
    cyc(0, 1, 1, 11'd9, 0, "R3");

    // R2: turn-off delay via ce1, then via ce2 with re-selection mid-count
    cyc(1, 1, 1, 11'd9, 0, "R2");
    cyc(1, 1, 1, 11'd9, 0, "R2");
    cyc(1, 1, 1, 11'd9, 0, "R2");
    cyc(0, 1, 1, 11'd5, 0, "R7");
    cyc(0, 1, 1, 11'd5, 0, "R7");
    cyc(0, 0, 1, 11'd5, 0, "R2");
    cyc(0, 1, 1, 11'd5, 0, "R2");
    cyc(0, 0, 1, 11'd5, 0, "R2");
    cyc(0, 0, 1, 11'd5, 0, "R2");
    cyc(0, 0, 1, 11'd5, 0, "R9");

    // R1: write attempts with one enable false, then read back
    cyc(1, 1, 0, 11'd5, 8'hFF, "R1");
    cyc(0, 0, 0, 11'd5, 8'hEE, "R1");
    cyc(1, 0, 0, 11'd5, 8'hDD, "R1");
    cyc(0, 1, 1, 11'd5, 0, "R1");
    cyc(0, 1, 1, 11'd5, 0, "R1");
    cyc(1, 1, 1, 11'd5, 0, "R1");
    cyc(1, 1, 1, 11'd5, 0, "R1");

    // R6: ce1 and we fall together, then we rises still selected
    cyc(0, 1, 0, 11'd12, 8'h77, "R6");
    cyc(0, 1, 0, 11'd12, 8'h77, "R6");
    cyc(0, 1, 1, 11'd12, 0, "R3");
    cyc(0, 1, 1, 11'd12, 0, "R3");
    // selected one edge before we falls: count never completes
    cyc(1, 1, 1, 11'd13, 0, "R6");
    cyc(1, 1, 1, 11'd13, 0, "R6");
    cyc(0, 1, 1, 11'd13, 8'h42, "R6");
    cyc(0, 1, 0, 11'd13, 8'h42, "R6");
    cyc(1, 1, 1, 11'd13, 0, "R6");

    // R11: reset pulse keeps array contents
    pulse_reset("R11");
    cyc(0, 1, 1, 11'h7FF, 0, "R11");
    cyc(0, 1, 1, 11'h7FF, 0, "R11");
    cyc(0, 1, 1, 11'd13, 0, "R11");
    cyc(1, 1, 1, 11'd13, 0, "R11");

    repeat (2) @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule